// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the memory address for one load or store of a 64-bit load/store machine. Each request carries a base register value, an index register value, an immediate, the program counter, the access size and an addressing form. The unit returns the address to access, the new base value and its enable for the forms that update the base, and a flag that marks an immediate (or encoding) that the chosen form cannot hold. Memory access, instruction decode and assembler pseudo-loads are handled elsewhere.

Requests arrive on a valid/ready stream and results leave on another. With the default `REG_OUT = 1` a one-entry output register sits between them. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle. A result is handed over on a rising edge where `out_valid` and `out_ready` are both high. Until then it stays fixed at the outputs. With `REG_OUT = 0` the unit is combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Immediates for the immediate forms are byte offsets. For the literal form the immediate is a signed count of 4-byte words. Form codes on `in_mode` are: 0 base only, 1 signed unscaled, 2 unsigned scaled, 3 pre-update, 4 post-update, 5 register index, 6 PC-relative literal, 7 reserved. Size codes on `in_size` are 0 byte, 1 halfword, 2 word, 3 doubleword. When `out_illegal` is high, `out_addr` and `out_wb_data` carry no meaning. `out_wb_data` also carries no meaning whenever `out_wb_en` is low.

Top module: `agu_top`

## Requirements
- R1: Form 0 gives the base value as the address, with no base update and no illegal flag.
- R2: Form 1 adds the sign-extended immediate, unshifted, to the base. An immediate outside -256..255 raises the illegal flag.
- R3: Form 2 adds the immediate to the base. The immediate must be non-negative, a multiple of the access size in bytes (1, 2, 4 or 8 for size codes 0..3), and no more than 4095 times that size (0x7ff8 for doublewords). Otherwise the illegal flag is raised.
- R4: Form 3 gives base plus signed immediate (range -256..255) as the address, and returns that same sum as the base update with its enable high.
- R5: Form 4 gives the unmodified base as the address, and returns base plus signed immediate (range -256..255) as the base update with its enable high.
- R6: Form 5 adds a transformed index to the base. `in_ext` picks the transform: 0 takes the whole 64-bit index, 1 sign-extends its low 32 bits, 2 zero-extends its low 32 bits, and 3 is illegal. When `in_shift` is high, the extended index is shifted left by the size code (0..3 bits) before the add.
- R7: Form 6 sign-extends the immediate as a 19-bit word count, shifts it left by 2 and adds it to the program counter. An immediate outside -262144..262143 raises the illegal flag.
- R8: Form 7 is illegal. An illegal request never enables a base update.
- R9: With the output register present, a result held while `out_ready` is low stays valid and unchanged, and `in_ready` equals NOT `out_valid` OR `out_ready`. Results leave in the order their requests were taken, with none lost or repeated.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 3 | Addressing form code |
| in_size | input | 2 | Access size code |
| in_base | input | 64 | Base register value |
| in_pc | input | 64 | Program counter |
| in_index | input | 64 | Index register value |
| in_imm | input | 32 | Immediate (bytes, or words for the literal form) |
| in_ext | input | 2 | Index extension select |
| in_shift | input | 1 | Scale the index by the access size |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 64 | Effective address |
| out_wb_en | output | 1 | Base update enable |
| out_wb_data | output | 64 | New base value |
| out_illegal | output | 1 | Immediate or encoding not allowed |

## Verification
Two things can happen in the same cycle at the output register: the held result is drained and a new request is loaded. The bench provokes this by streaming requests back to back while `out_ready` follows a pseudo-random pattern. Some cycles therefore take a request and hand one over on the same edge, and others stall. A scoreboard fed in acceptance order judges each item, so any overwrite, duplicate or drop shows up as a mismatch or as a count left over at the end. Each stalled cycle is also checked to hold its result unchanged into the next cycle.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int XLEN  = 64;
  localparam int IMM_W = 32;

  typedef enum logic [2:0] {
    AM_BASE = 3'd0,
    AM_SIMM = 3'd1,
    AM_UIMM = 3'd2,
    AM_PRE  = 3'd3,
    AM_POST = 3'd4,
    AM_REG  = 3'd5,
    AM_LIT  = 3'd6,
    AM_RSVD = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    IX_FULL = 2'd0,
    IX_SX32 = 2'd1,
    IX_ZX32 = 2'd2,
    IX_RSVD = 2'd3
  } ixext_e;

  typedef struct packed {
    logic [XLEN-1:0] addr;
    logic            wb_en;
    logic [XLEN-1:0] wb_data;
    logic            illegal;
  } agu_res_t;
endpackage

// File: rtl/agu_offset.sv
module agu_offset
  import agu_pkg::*;
#(
  parameter int SIMM_W = 9,
  parameter int UIMM_W = 12,
  parameter int LIT_W  = 19
) (
  input  amode_e           mode,
  input  logic [1:0]       size,
  input  logic [XLEN-1:0]  index,
  input  logic [IMM_W-1:0] imm,
  input  ixext_e           ext,
  input  logic             shift_en,
  output logic [XLEN-1:0]  offset,
  output logic             illegal
);
  localparam int HALF = XLEN / 2;

  logic [IMM_W-SIMM_W:0] simm_top;
  logic [IMM_W-LIT_W:0]  lit_top;
  logic                  simm_ok, lit_ok, uimm_ok;
  logic [IMM_W-1:0]      align_mask, upper;
  logic [XLEN-1:0]       imm_sx, lit_sx, idx_x;

  assign simm_top = imm[IMM_W-1:SIMM_W-1];
  assign lit_top  = imm[IMM_W-1:LIT_W-1];
  assign simm_ok  = (&simm_top) | ~(|simm_top);
  assign lit_ok   = (&lit_top) | ~(|lit_top);

  assign align_mask = (IMM_W'(1) << size) - IMM_W'(1);
  assign upper      = imm >> (UIMM_W + int'(size));
  assign uimm_ok    = (upper == '0) && ((imm & align_mask) == '0);

  assign imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign lit_sx = {{(XLEN-LIT_W){imm[LIT_W-1]}}, imm[LIT_W-1:0]} << 2;

  always_comb begin
    unique case (ext)
      IX_SX32: idx_x = {{HALF{index[HALF-1]}}, index[HALF-1:0]};
      IX_ZX32: idx_x = {{HALF{1'b0}}, index[HALF-1:0]};
      default: idx_x = index;
    endcase
  end

  always_comb begin
    offset  = '0;
    illegal = 1'b0;
    unique case (mode)
      AM_BASE: offset = '0;
      AM_SIMM, AM_PRE, AM_POST: begin
        offset  = imm_sx;
        illegal = !simm_ok;
      end
      AM_UIMM: begin
        offset  = imm_sx;
        illegal = !uimm_ok;
      end
      AM_REG: begin
        offset  = shift_en ? (idx_x << size) : idx_x;
        illegal = (ext == IX_RSVD);
      end
      AM_LIT: begin
        offset  = lit_sx;
        illegal = !lit_ok;
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_sum.sv
module agu_sum
  import agu_pkg::*;
(
  input  amode_e          mode,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] offset,
  input  logic            illegal,
  output agu_res_t        res
);
  logic [XLEN-1:0] opnd, sum;

  assign opnd = (mode == AM_LIT) ? pc : base;
  assign sum  = opnd + offset;

  always_comb begin
    res.addr    = (mode == AM_POST) ? base : sum;
    res.wb_data = sum;
    res.wb_en   = ((mode == AM_PRE) || (mode == AM_POST)) && !illegal;
    res.illegal = illegal;
  end
endmodule

// File: rtl/agu_outreg.sv
module agu_outreg #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else if (in_ready) vld_q <= in_valid;
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) dat_q <= in_data;
      end

      // R9: a stalled result stays put
      a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      // R9: ready rule
      a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready));
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter int SIMM_W  = 9,
  parameter int UIMM_W  = 12,
  parameter int LIT_W   = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_mode,
  input  logic [1:0]       in_size,
  input  logic [XLEN-1:0]  in_base,
  input  logic [XLEN-1:0]  in_pc,
  input  logic [XLEN-1:0]  in_index,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [1:0]       in_ext,
  input  logic             in_shift,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_addr,
  output logic             out_wb_en,
  output logic [XLEN-1:0]  out_wb_data,
  output logic             out_illegal
);
  localparam int RES_W = $bits(agu_res_t);

  amode_e          mode;
  logic [XLEN-1:0] offset;
  logic            illegal;
  agu_res_t        res, res_q;

  assign mode = amode_e'(in_mode);

  agu_offset #(.SIMM_W(SIMM_W), .UIMM_W(UIMM_W), .LIT_W(LIT_W)) u_off (
    .mode(mode), .size(in_size), .index(in_index), .imm(in_imm),
    .ext(ixext_e'(in_ext)), .shift_en(in_shift),
    .offset(offset), .illegal(illegal)
  );

  agu_sum u_sum (
    .mode(mode), .base(in_base), .pc(in_pc), .offset(offset),
    .illegal(illegal), .res(res)
  );

  // R5: post form addresses the unmodified base
  a_r5_post_base: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == AM_POST) |-> (res.addr == in_base));
  // R4: pre form addresses exactly what it writes back
  a_r4_pre_same: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == AM_PRE && !res.illegal) |-> (res.addr == res.wb_data));
  // R7: literal keeps the program counter's word alignment
  a_r7_lit_align: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == AM_LIT) |-> (res.addr[1:0] == in_pc[1:0]));
  // R1: base only adds nothing
  a_r1_base_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == AM_BASE) |-> (res.addr == in_base && !res.illegal));

  agu_outreg #(.W(RES_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q)
  );

  assign out_addr    = res_q.addr;
  assign out_wb_en   = res_q.wb_en;
  assign out_wb_data = res_q.wb_data;
  assign out_illegal = res_q.illegal;

  // R8: illegal never updates the base
  a_r8_no_wb_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_wb_en && out_illegal));
endmodule

// File: tb/test_agu_top.sv
`timescale 1ns/100ps
module test_agu_top;
  import agu_pkg::*;

  typedef struct {
    agu_res_t r;
    string    tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_shift = 1'b0, out_valid, out_ready = 1'b1;
  logic [2:0] in_mode = '0;
  logic [1:0] in_size = '0, in_ext = '0;
  logic [63:0] in_base = '0, in_pc = '0, in_index = '0;
  logic [31:0] in_imm = '0;
  logic [63:0] out_addr, out_wb_data;
  logic out_wb_en, out_illegal;

  int checks = 0, errors = 0, received = 0, sent = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  agu_top i_agu_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_size(in_size), .in_base(in_base), .in_pc(in_pc),
    .in_index(in_index), .in_imm(in_imm), .in_ext(in_ext), .in_shift(in_shift),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_wb_en(out_wb_en), .out_wb_data(out_wb_data), .out_illegal(out_illegal)
  );

  function automatic agu_res_t model(input logic [2:0] m, input logic [1:0] s,
      input logic [63:0] b, p, x, input logic [31:0] im, input logic [1:0] e,
      input logic sh);
    agu_res_t r;
    longint signed si, unit;
    logic [63:0] idx;
    r = '0;
    si = longint'($signed(im));
    unit = longint'(1) << s;
    case (m)
      3'd0: r.addr = b;
      3'd1, 3'd3, 3'd4: begin
        r.illegal = (si < -256) || (si > 255);
        r.wb_data = b + 64'(si);
        r.addr = (m == 3'd4) ? b : b + 64'(si);
      end
      3'd2: begin
        r.illegal = (si < 0) || ((si % unit) != 0) || (si > 4095 * unit);
        r.addr = b + 64'(si);
      end
      3'd5: begin
        if (e == 2'd1) idx = 64'(longint'($signed(x[31:0])));
        else if (e == 2'd2) idx = {32'h0, x[31:0]};
        else idx = x;
        r.illegal = (e == 2'd3);
        r.addr = b + (sh ? idx * 64'(unit) : idx);
      end
      3'd6: begin
        r.illegal = (si < -262144) || (si > 262143);
        r.addr = p + 64'(si * 4);
      end
      default: r.illegal = 1'b1;
    endcase
    r.wb_en = (m == 3'd3 || m == 3'd4) && !r.illegal;
    return r;
  endfunction

  // Driver: called at a falling edge, returns at a falling edge.
  task automatic drive(input logic [2:0] m, input logic [1:0] s,
      input logic [63:0] b, p, x, input logic [31:0] im, input logic [1:0] e,
      input logic sh, input string tag);
    exp_t ex;
    ex.r = model(m, s, b, p, x, im, e, sh);
    ex.tag = tag;
    in_mode = m; in_size = s; in_base = b; in_pc = p; in_index = x;
    in_imm = im; in_ext = e; in_shift = sh; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    sb.push_back(ex);
    sent++;
    @(negedge clk);
  endtask

  // Consumer back-pressure, changed just after each rising edge.
  logic [15:0] lfsr = 16'hace1;
  bit bp_on = 1'b0;
  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // Monitor / scoreboard
  logic        stall_q = 1'b0;
  logic [63:0] stall_addr;
  logic        stall_ill;
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (stall_q) begin
        checks++;
        if (!out_valid || out_addr !== stall_addr || out_illegal !== stall_ill) begin
          errors++;
          $display("FAIL R9 hold: valid=%0b addr=%h ill=%0b expected valid=1 addr=%h ill=%0b",
                   out_valid, out_addr, out_illegal, stall_addr, stall_ill);
        end
      end
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        errors++;
        $display("FAIL R9 ready: got %0b expected %0b", in_ready, (!out_valid || out_ready));
      end
      stall_q = out_valid && !out_ready;
      stall_addr = out_addr;
      stall_ill = out_illegal;
      if (out_valid && out_ready) begin
        exp_t ex;
        received++;
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R9 extra result addr=%h expected none", out_addr);
        end else begin
          ex = sb.pop_front();
          if (out_illegal !== ex.r.illegal || out_wb_en !== ex.r.wb_en ||
              (!ex.r.illegal && out_addr !== ex.r.addr) ||
              (ex.r.wb_en && out_wb_data !== ex.r.wb_data)) begin
            errors++;
            $display("FAIL %s: addr=%h wb=%0b/%h ill=%0b expected addr=%h wb=%0b/%h ill=%0b",
                     ex.tag, out_addr, out_wb_en, out_wb_data, out_illegal,
                     ex.r.addr, ex.r.wb_en, ex.r.wb_data, ex.r.illegal);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_set(input string pass);
    logic [63:0] B;
    B = 64'h0000_1000_0000_8000;
    drive(3'd0, 2'd3, B, 0, 0, 32'd77, 2'd0, 1'b0, "R1 base only");
    drive(3'd1, 2'd3, B, 0, 0, 32'd255, 2'd0, 1'b0, "R2 simm max");
    drive(3'd1, 2'd0, B, 0, 0, -32'sd256, 2'd0, 1'b0, "R2 simm min");
    drive(3'd1, 2'd0, B, 0, 0, 32'd256, 2'd0, 1'b0, "R2 simm over");
    drive(3'd1, 2'd0, B, 0, 0, -32'sd257, 2'd0, 1'b0, "R2 simm under");
    drive(3'd2, 2'd3, B, 0, 0, 32'h7ff8, 2'd0, 1'b0, "R3 dword max");
    drive(3'd2, 2'd3, B, 0, 0, 32'h8000, 2'd0, 1'b0, "R3 dword over");
    drive(3'd2, 2'd3, B, 0, 0, 32'h7ff4, 2'd0, 1'b0, "R3 dword misaligned");
    drive(3'd2, 2'd2, B, 0, 0, 32'h3ffc, 2'd0, 1'b0, "R3 word max");
    drive(3'd2, 2'd1, B, 0, 0, 32'h1fff, 2'd0, 1'b0, "R3 half odd");
    drive(3'd2, 2'd0, B, 0, 0, 32'hfff, 2'd0, 1'b0, "R3 byte max");
    drive(3'd2, 2'd0, B, 0, 0, -32'sd8, 2'd0, 1'b0, "R3 negative");
    drive(3'd3, 2'd3, B, 0, 0, -32'sd80, 2'd0, 1'b0, "R4 pre neg");
    drive(3'd3, 2'd3, B, 0, 0, 32'd300, 2'd0, 1'b0, "R8 pre illegal");
    drive(3'd4, 2'd3, B, 0, 0, 32'd16, 2'd0, 1'b0, "R5 post");
    drive(3'd4, 2'd3, B, 0, 0, -32'sd256, 2'd0, 1'b0, "R5 post min");
    drive(3'd5, 2'd3, B, 0, 64'h1234_5678_0000_0010, 0, 2'd0, 1'b1, "R6 full shift3");
    drive(3'd5, 2'd2, B, 0, 64'hdead_beef_ffff_fffc, 0, 2'd1, 1'b1, "R6 sx32 shift2");
    drive(3'd5, 2'd1, B, 0, 64'hdead_beef_ffff_fffc, 0, 2'd2, 1'b1, "R6 zx32 shift1");
    drive(3'd5, 2'd3, B, 0, 64'h0000_0000_8000_0000, 0, 2'd1, 1'b0, "R6 sx32 noshift");
    drive(3'd5, 2'd0, B, 0, 64'h55, 0, 2'd0, 1'b1, "R6 byte shift0");
    drive(3'd5, 2'd3, B, 0, 64'h55, 0, 2'd3, 1'b0, "R6 ext reserved");
    drive(3'd6, 2'd3, 0, 64'h0000_0000_0040_0000, 0, 32'h3ffff, 2'd0, 1'b0, "R7 lit max");
    drive(3'd6, 2'd3, 0, 64'h0000_0000_0040_0000, 0, -32'sd262144, 2'd0, 1'b0, "R7 lit min");
    drive(3'd6, 2'd3, 0, 64'h0000_0000_0040_0000, 0, 32'h40000, 2'd0, 1'b0, "R7 lit over");
    drive(3'd7, 2'd3, B, 0, 0, 32'd0, 2'd0, 1'b0, "R8 reserved form");
    $display("set %s sent", pass);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 out_valid in reset: got %0b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 after reset: valid=%0b ready=%0b expected 0 1", out_valid, in_ready);
    end
    run_set("free-flowing");
    bp_on = 1'b1;
    run_set("back-pressured");
    in_valid = 1'b0;
    for (int i = 0; i < 200 && sb.size() != 0; i++) @(negedge clk);
    bp_on = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (received != sent || sb.size() != 0) begin
      errors++;
      $display("FAIL R9 count: received %0d expected %0d", received, sent);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule